// File: doc/BRIEF.md
# Shadow Scan State Swap Sequencer

This block keeps a shadow copy of a small bank of live processor state, one shadow word for every live word, so that the logic around that state can be tested while the chip is in the field. Software fills the shadow words with a test pattern, one word at a time. It can write them directly or copy them from a small set of architectural registers. Software then issues a start command.

The block answers with an atomic three-cycle sequence. First it exchanges the shadow and live banks, so the live registers hold the pattern and the shadow holds the machine's real state. Next it lets a stand-in combinational function, which models the logic under test, clock the live bank once. Last it exchanges the two banks again. When the sequence ends, the shadow bank holds the captured response and the live bank holds its pre-test contents. Software reads the response back through a registered read port or copies it into an architectural register. Comparing the response with the expected one is left to the software.

While the sequence runs, the block raises a busy flag. During that time it freezes ordinary live-state updates and ignores software access to the shadow bank. One cycle after the sequence ends, it gives a single-cycle done pulse.

Top module: `scan_swap_seq`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and every live word, shadow word and architectural register reads 0.
- R2: When `sh_we` is high in an idle cycle, the edge writes `sh_wdata` into shadow word `sh_widx`. `sh_rdata` is registered: after each edge it shows the shadow word that `sh_ridx` selected in the cycle before that edge.
- R3: A `start` sampled high while idle makes `busy` read 1 for exactly three cycles. In the cycle where `busy` returns to 0, `done` reads 1, and only in that cycle.
- R4: A `start` sampled while `busy` is 1 has no effect. The running sequence ends on schedule and no second sequence follows.
- R5: Cycle 1 of the sequence exchanges the live and shadow banks and cycle 3 exchanges them again. After the sequence, the shadow bank holds the test response and the live bank again holds its pre-test contents.
- R6: When `live_we` is high while idle, the edge writes `live_wdata` into live word `live_widx`. While `busy` is 1, `live_we` is ignored. `live_rdata` is a combinational read of live word `live_ridx`.
- R7: While `busy` is 1, the shadow bank ignores `sh_we` and `xfer_en` in either direction, and no architectural register changes because of `xfer_en`.
- R8: With `xfer_en` high and `xfer_dir`=1 while idle, the edge copies architectural register `xfer_ar_idx` into shadow word `xfer_sh_idx`. If `sh_we` targets the same word in the same cycle, the copied value wins.
- R9: With `xfer_en` high and `xfer_dir`=0 while idle, the edge copies shadow word `xfer_sh_idx` into architectural register `xfer_ar_idx`. If `ar_we` targets the same register in the same cycle, the copied value wins. `ar_rdata` is a combinational read of register `ar_ridx`.
- R10: In the functional test cycle, each live word i is replaced by its own value rotated left by one bit, XOR live word (i+1) modulo the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the swap-test-swap sequence |
| busy | output | 1 | High while the three-cycle sequence runs |
| done | output | 1 | One-cycle pulse after the sequence ends |
| sh_we | input | 1 | Shadow word write enable |
| sh_widx | input | log2(NUM_WORDS) | Shadow word write index |
| sh_wdata | input | WORD_W | Shadow word write data |
| sh_ridx | input | log2(NUM_WORDS) | Shadow word read index |
| sh_rdata | output | WORD_W | Registered shadow word read data |
| live_we | input | 1 | Ordinary live-state update enable |
| live_widx | input | log2(NUM_WORDS) | Live word update index |
| live_wdata | input | WORD_W | Live word update data |
| live_ridx | input | log2(NUM_WORDS) | Live word read index |
| live_rdata | output | WORD_W | Combinational live word read data |
| ar_we | input | 1 | Architectural register write enable |
| ar_widx | input | log2(NUM_ARCH) | Architectural register write index |
| ar_wdata | input | WORD_W | Architectural register write data |
| ar_ridx | input | log2(NUM_ARCH) | Architectural register read index |
| ar_rdata | output | WORD_W | Combinational architectural register read data |
| xfer_en | input | 1 | Transfer between an architectural register and a shadow word |
| xfer_dir | input | 1 | 1: register into shadow, 0: shadow into register |
| xfer_sh_idx | input | log2(NUM_WORDS) | Shadow word taking part in the transfer |
| xfer_ar_idx | input | log2(NUM_ARCH) | Architectural register taking part in the transfer |

## Verification
The properties assume that reset is held through the first clock edge and that the word indices stay below the word count. The stimulus keeps to both: the default configuration has a power-of-two count, so every index value is valid. The properties also assume that a start request reaches the block only through `start`. During the busy window, the bench deliberately drives `start`, live updates, shadow writes and transfers in both directions, and then shows through the read ports that none of them took effect. Expected responses come from the rotate-and-XOR rule applied to the loaded pattern, across zero, all-ones, walking-bit and arithmetic patterns.

// File: rtl/scan_swap_pkg.sv
package scan_swap_pkg;

    // Sequence phases; the order is the order of the atomic test.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_SWAP_IN  = 2'd1,
        PH_EVAL     = 2'd2,
        PH_SWAP_OUT = 2'd3
    } phase_e;

    // Direction of a register/shadow transfer.
    typedef enum logic {
        XF_INTO_ARCH   = 1'b0,
        XF_INTO_SHADOW = 1'b1
    } xfer_dir_e;

    // Per-cycle controls decoded from the phase.
    typedef struct packed {
        logic busy;
        logic swap;
        logic eval;
        logic last;
    } seq_ctl_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic phase_e phase_next(input phase_e p, input logic go);
        case (p)
            PH_IDLE:     return go ? PH_SWAP_IN : PH_IDLE;
            PH_SWAP_IN:  return PH_EVAL;
            PH_EVAL:     return PH_SWAP_OUT;
            default:     return PH_IDLE;
        endcase
    endfunction

    function automatic seq_ctl_t phase_decode(input phase_e p);
        seq_ctl_t c;
        c.busy = (p != PH_IDLE);
        c.swap = (p == PH_SWAP_IN) || (p == PH_SWAP_OUT);
        c.eval = (p == PH_EVAL);
        c.last = (p == PH_SWAP_OUT);
        return c;
    endfunction

endpackage

// File: rtl/swap_sequencer.sv
module swap_sequencer
    import scan_swap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output phase_e   phase_q,
    output seq_ctl_t ctl,
    output logic     done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_next(phase_q, start);
            done_q  <= (phase_q == PH_SWAP_OUT);
        end
    end

    assign ctl = phase_decode(phase_q);

endmodule

// File: rtl/test_logic_stub.sv
module test_logic_stub #(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 4
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] cur,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] nxt
);

    // Each word: rotate left by one, mixed with its upper neighbour.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam int NB = (i + 1) % NUM_WORDS;
        assign nxt[i] = {cur[i][WORD_W-2:0], cur[i][WORD_W-1]} ^ cur[NB];
    end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import scan_swap_pkg::*;
#(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             swap,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] live_in,
    input  logic                             wr_en,
    input  logic [idx_w(NUM_WORDS)-1:0]      wr_idx,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic                             xf_load,
    input  logic [idx_w(NUM_WORDS)-1:0]      xf_idx,
    input  logic [WORD_W-1:0]                xf_data,
    output logic [WORD_W-1:0]                xf_rd_data,
    input  logic [idx_w(NUM_WORDS)-1:0]      rd_idx,
    output logic [WORD_W-1:0]                rd_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q
);

    localparam int AW = idx_w(NUM_WORDS);

    logic rd_ok;
    logic xf_ok;

    assign rd_ok = (int'(rd_idx) < NUM_WORDS);
    assign xf_ok = (int'(xf_idx) < NUM_WORDS);

    assign xf_rd_data = xf_ok ? bank_q[xf_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= '0;
            rd_data <= '0;
        end else begin
            if (swap) begin
                bank_q <= live_in;
            end else begin
                for (int k = 0; k < NUM_WORDS; k++) begin
                    if (wr_en && (wr_idx == AW'(k)))
                        bank_q[k] <= wr_data;
                    // Transfer is written last so it wins on a collision.
                    if (xf_load && (xf_idx == AW'(k)))
                        bank_q[k] <= xf_data;
                end
            end
            rd_data <= rd_ok ? bank_q[rd_idx] : '0;
        end
    end

endmodule

// File: rtl/live_bank.sv
module live_bank
    import scan_swap_pkg::*;
#(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             swap,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_in,
    input  logic                             eval,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] eval_in,
    input  logic                             freeze,
    input  logic                             wr_en,
    input  logic [idx_w(NUM_WORDS)-1:0]      wr_idx,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic [idx_w(NUM_WORDS)-1:0]      rd_idx,
    output logic [WORD_W-1:0]                rd_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q
);

    localparam int AW = idx_w(NUM_WORDS);

    assign rd_data = (int'(rd_idx) < NUM_WORDS) ? bank_q[rd_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (swap) begin
            bank_q <= shadow_in;
        end else if (eval) begin
            bank_q <= eval_in;
        end else if (!freeze) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (wr_en && (wr_idx == AW'(k)))
                    bank_q[k] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/arch_regs.sv
module arch_regs
    import scan_swap_pkg::*;
#(
    parameter int WORD_W   = 64,
    parameter int NUM_ARCH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [idx_w(NUM_ARCH)-1:0]  wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        xf_load,
    input  logic [idx_w(NUM_ARCH)-1:0]  xf_idx,
    input  logic [WORD_W-1:0]           xf_data,
    output logic [WORD_W-1:0]           xf_rd_data,
    input  logic [idx_w(NUM_ARCH)-1:0]  rd_idx,
    output logic [WORD_W-1:0]           rd_data
);

    localparam int AW = idx_w(NUM_ARCH);

    logic [NUM_ARCH-1:0][WORD_W-1:0] regs_q;

    assign rd_data    = (int'(rd_idx) < NUM_ARCH) ? regs_q[rd_idx] : '0;
    assign xf_rd_data = (int'(xf_idx) < NUM_ARCH) ? regs_q[xf_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int k = 0; k < NUM_ARCH; k++) begin
                if (wr_en && (wr_idx == AW'(k)))
                    regs_q[k] <= wr_data;
                if (xf_load && (xf_idx == AW'(k)))
                    regs_q[k] <= xf_data;
            end
        end
    end

endmodule

// File: rtl/scan_swap_seq.sv
module scan_swap_seq
    import scan_swap_pkg::*;
#(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 4,
    parameter int NUM_ARCH  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    input  logic                        sh_we,
    input  logic [idx_w(NUM_WORDS)-1:0] sh_widx,
    input  logic [WORD_W-1:0]           sh_wdata,
    input  logic [idx_w(NUM_WORDS)-1:0] sh_ridx,
    output logic [WORD_W-1:0]           sh_rdata,
    input  logic                        live_we,
    input  logic [idx_w(NUM_WORDS)-1:0] live_widx,
    input  logic [WORD_W-1:0]           live_wdata,
    input  logic [idx_w(NUM_WORDS)-1:0] live_ridx,
    output logic [WORD_W-1:0]           live_rdata,
    input  logic                        ar_we,
    input  logic [idx_w(NUM_ARCH)-1:0]  ar_widx,
    input  logic [WORD_W-1:0]           ar_wdata,
    input  logic [idx_w(NUM_ARCH)-1:0]  ar_ridx,
    output logic [WORD_W-1:0]           ar_rdata,
    input  logic                        xfer_en,
    input  logic                        xfer_dir,
    input  logic [idx_w(NUM_WORDS)-1:0] xfer_sh_idx,
    input  logic [idx_w(NUM_ARCH)-1:0]  xfer_ar_idx
);

    phase_e   phase_q;
    seq_ctl_t ctl;

    logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] live_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] eval_next;

    logic              sw_open;
    logic              to_shadow;
    logic              to_arch;
    logic [WORD_W-1:0] arch_src;
    logic [WORD_W-1:0] shadow_src;

    swap_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phase_q (phase_q),
        .ctl     (ctl),
        .done_q  (done)
    );

    assign busy      = ctl.busy;
    assign sw_open   = !ctl.busy;
    assign to_shadow = sw_open && xfer_en && (xfer_dir_e'(xfer_dir) == XF_INTO_SHADOW);
    assign to_arch   = sw_open && xfer_en && (xfer_dir_e'(xfer_dir) == XF_INTO_ARCH);

    test_logic_stub #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_stub (
        .cur (live_q),
        .nxt (eval_next)
    );

    shadow_bank #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .swap       (ctl.swap),
        .live_in    (live_q),
        .wr_en      (sw_open && sh_we),
        .wr_idx     (sh_widx),
        .wr_data    (sh_wdata),
        .xf_load    (to_shadow),
        .xf_idx     (xfer_sh_idx),
        .xf_data    (arch_src),
        .xf_rd_data (shadow_src),
        .rd_idx     (sh_ridx),
        .rd_data    (sh_rdata),
        .bank_q     (shadow_q)
    );

    live_bank #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_live (
        .clk       (clk),
        .rst       (rst),
        .swap      (ctl.swap),
        .shadow_in (shadow_q),
        .eval      (ctl.eval),
        .eval_in   (eval_next),
        .freeze    (ctl.busy),
        .wr_en     (live_we),
        .wr_idx    (live_widx),
        .wr_data   (live_wdata),
        .rd_idx    (live_ridx),
        .rd_data   (live_rdata),
        .bank_q    (live_q)
    );

    arch_regs #(
        .WORD_W   (WORD_W),
        .NUM_ARCH (NUM_ARCH)
    ) u_arch (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ar_we),
        .wr_idx     (ar_widx),
        .wr_data    (ar_wdata),
        .xf_load    (to_arch),
        .xf_idx     (xfer_ar_idx),
        .xf_data    (shadow_src),
        .xf_rd_data (arch_src),
        .rd_idx     (ar_ridx),
        .rd_data    (ar_rdata)
    );

endmodule

// File: rtl/scan_swap_seq_chk.sv
module scan_swap_seq_chk
    import scan_swap_pkg::*;
#(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 4
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             start,
    input logic                             busy,
    input logic                             done,
    input phase_e                           phase,
    input logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_q,
    input logic [NUM_WORDS-1:0][WORD_W-1:0] live_q,
    input logic [idx_w(NUM_WORDS)-1:0]      sh_ridx,
    input logic [WORD_W-1:0]                sh_rdata
);

    logic              past_ok;
    logic [WORD_W-1:0] sel_word;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign sel_word = (int'(sh_ridx) < NUM_WORDS) ? shadow_q[sh_ridx] : '0;

    a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (sh_rdata == $past(sel_word)));

    a_r3_busy_three: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    a_r3_done_at_end: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_idle_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    a_r4_no_early_exit: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_SWAP_OUT) |=> busy);

    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWAP_OUT) |=> !busy);

    a_r5_swap_in: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWAP_IN) |=>
            (shadow_q == $past(live_q)) && (live_q == $past(shadow_q)));

    a_r5_swap_out: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWAP_OUT) |=>
            (shadow_q == $past(live_q)) && (live_q == $past(shadow_q)));

    a_r7_eval_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EVAL) |=> $stable(shadow_q));

endmodule

bind scan_swap_seq scan_swap_seq_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .phase    (phase_q),
    .shadow_q (shadow_q),
    .live_q   (live_q),
    .sh_ridx  (sh_ridx),
    .sh_rdata (sh_rdata)
);

// File: tb/tb_scan_swap_seq.sv
`timescale 1ns/1ps
module tb_scan_swap_seq;
    localparam int W  = 64;
    localparam int N  = 4;
    localparam int R  = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy, done;
    logic          sh_we = 1'b0;
    logic [AW-1:0] sh_widx = '0, sh_ridx = '0;
    logic [W-1:0]  sh_wdata = '0, sh_rdata;
    logic          live_we = 1'b0;
    logic [AW-1:0] live_widx = '0, live_ridx = '0;
    logic [W-1:0]  live_wdata = '0, live_rdata;
    logic          ar_we = 1'b0;
    logic [AW-1:0] ar_widx = '0, ar_ridx = '0;
    logic [W-1:0]  ar_wdata = '0, ar_rdata;
    logic          xfer_en = 1'b0, xfer_dir = 1'b0;
    logic [AW-1:0] xfer_sh_idx = '0, xfer_ar_idx = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    scan_swap_seq #(.WORD_W(W), .NUM_WORDS(N), .NUM_ARCH(R)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .sh_we(sh_we), .sh_widx(sh_widx), .sh_wdata(sh_wdata),
        .sh_ridx(sh_ridx), .sh_rdata(sh_rdata),
        .live_we(live_we), .live_widx(live_widx), .live_wdata(live_wdata),
        .live_ridx(live_ridx), .live_rdata(live_rdata),
        .ar_we(ar_we), .ar_widx(ar_widx), .ar_wdata(ar_wdata),
        .ar_ridx(ar_ridx), .ar_rdata(ar_rdata),
        .xfer_en(xfer_en), .xfer_dir(xfer_dir),
        .xfer_sh_idx(xfer_sh_idx), .xfer_ar_idx(xfer_ar_idx)
    );

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc;
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] rotl1(input logic [W-1:0] v);
        return {v[W-2:0], v[W-1]};
    endfunction

    function automatic logic [W-1:0] pattern(input int p, input int i);
        case (p)
            0: return '0;
            1: return '1;
            2: return 64'h1 << (i * 17 + 3);
            default: return (64'h9E37_79B9_7F4A_7C15 * 64'(p * 4 + i + 1)) ^ 64'(i << 40);
        endcase
    endfunction

    task automatic sh_write(input int k, input logic [W-1:0] d);
        sh_we = 1'b1; sh_widx = AW'(k); sh_wdata = d;
        cyc;
        sh_we = 1'b0;
    endtask

    task automatic sh_read(input int k, output logic [W-1:0] d);
        sh_ridx = AW'(k);
        cyc;
        d = sh_rdata;
    endtask

    task automatic live_write(input int k, input logic [W-1:0] d);
        live_we = 1'b1; live_widx = AW'(k); live_wdata = d;
        cyc;
        live_we = 1'b0;
    endtask

    task automatic live_read(input int k, output logic [W-1:0] d);
        live_ridx = AW'(k);
        #1 d = live_rdata;
    endtask

    task automatic ar_write(input int k, input logic [W-1:0] d);
        ar_we = 1'b1; ar_widx = AW'(k); ar_wdata = d;
        cyc;
        ar_we = 1'b0;
    endtask

    task automatic ar_read(input int k, output logic [W-1:0] d);
        ar_ridx = AW'(k);
        #1 d = ar_rdata;
    endtask

    task automatic xfer(input logic dir, input int sk, input int aj);
        xfer_en = 1'b1; xfer_dir = dir; xfer_sh_idx = AW'(sk); xfer_ar_idx = AW'(aj);
        cyc;
        xfer_en = 1'b0;
    endtask

    // One full test run with a given pattern index.
    task automatic run_pattern(input int p, input bit junk);
        logic [W-1:0] pv [N];
        logic [W-1:0] lv [N];
        logic [W-1:0] av [R];
        logic [W-1:0] d;
        for (int i = 0; i < N; i++) begin
            pv[i] = pattern(p, i);
            lv[i] = ~pattern(p + 7, i) ^ 64'(i);
            sh_write(i, pv[i]);
            live_write(i, lv[i]);
        end
        for (int i = 0; i < N; i++) begin
            sh_read(i, d);
            chk("R2 shadow readback", d, pv[i]);
            live_read(i, d);
            chk("R6 idle live write", d, lv[i]);
        end
        for (int j = 0; j < R; j++) ar_read(j, av[j]);

        start = 1'b1;
        cyc;                                   // sequence accepted
        start = 1'b0;
        chk("R3 busy cycle 1", 64'(busy), 64'd1);
        if (junk) begin
            start = 1'b1;                      // R4 ignored start
            live_we = 1'b1; live_widx = 2'd1; live_wdata = 64'hDEAD_BEEF_0000_0001;
            sh_we = 1'b1; sh_widx = 2'd2; sh_wdata = 64'hDEAD_BEEF_0000_0002;
            xfer_en = 1'b1; xfer_dir = 1'b1; xfer_sh_idx = 2'd0; xfer_ar_idx = 2'd3;
        end
        cyc;
        chk("R3 busy cycle 2", 64'(busy), 64'd1);
        if (junk) begin
            xfer_dir = 1'b0; xfer_ar_idx = 2'd1; xfer_sh_idx = 2'd3;
        end
        cyc;
        chk("R3 busy cycle 3", 64'(busy), 64'd1);
        if (junk) xfer_dir = 1'b1;
        cyc;
        chk("R3 busy falls", 64'(busy), 64'd0);
        chk("R3 done pulse", 64'(done), 64'd1);
        start = 1'b0; live_we = 1'b0; sh_we = 1'b0; xfer_en = 1'b0;
        cyc;
        chk("R3 done single", 64'(done), 64'd0);
        chk("R4 no second run", 64'(busy), 64'd0);
        cyc;
        chk("R4 still idle", 64'(busy), 64'd0);

        for (int i = 0; i < N; i++) begin
            sh_read(i, d);
            chk("R10 response word", d, rotl1(pv[i]) ^ pv[(i + 1) % N]);
            live_read(i, d);
            chk("R5 live restored", d, lv[i]);
        end
        for (int j = 0; j < R; j++) begin
            ar_read(j, d);
            chk("R7 arch untouched by busy xfer", d, av[j]);
        end
    endtask

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] av [R];
        repeat (3) cyc;
        rst = 1'b0;
        #1;
        chk("R1 busy at reset", 64'(busy), 64'd0);
        chk("R1 done at reset", 64'(done), 64'd0);
        for (int i = 0; i < N; i++) begin
            live_read(i, d);
            chk("R1 live zero", d, '0);
        end
        for (int j = 0; j < R; j++) begin
            ar_read(j, d);
            chk("R1 arch zero", d, '0);
        end
        for (int i = 0; i < N; i++) begin
            sh_read(i, d);
            chk("R1 shadow zero", d, '0);
        end

        for (int p = 0; p < 8; p++) run_pattern(p, p >= 2);

        // Architectural register to shadow, every pairing (R8).
        for (int j = 0; j < R; j++) begin
            av[j] = 64'hA5A5_0000_0000_0000 | 64'(j * 32'h0101_0101 + 7);
            ar_write(j, av[j]);
        end
        for (int j = 0; j < R; j++) begin
            for (int k = 0; k < N; k++) begin
                xfer(1'b1, k, j);
                sh_read(k, d);
                chk("R8 reg into shadow", d, av[j]);
            end
        end
        // Shadow to architectural register, every pairing (R9).
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < R; j++) begin
                sh_write(k, 64'h5A00_0000_0000_0000 | 64'(k * 16 + j));
                xfer(1'b0, k, j);
                ar_read(j, d);
                chk("R9 shadow into reg", d, 64'h5A00_0000_0000_0000 | 64'(k * 16 + j));
            end
        end
        // Collisions: the transfer wins.
        ar_write(2, 64'h0000_1111_2222_3333);
        sh_we = 1'b1; sh_widx = 2'd1; sh_wdata = 64'hFFFF_0000_FFFF_0000;
        xfer(1'b1, 1, 2);
        sh_we = 1'b0;
        sh_read(1, d);
        chk("R8 transfer beats direct write", d, 64'h0000_1111_2222_3333);
        sh_write(3, 64'h7777_8888_9999_AAAA);
        ar_we = 1'b1; ar_widx = 2'd0; ar_wdata = 64'h1234_0000_0000_4321;
        xfer(1'b0, 3, 0);
        ar_we = 1'b0;
        ar_read(0, d);
        chk("R9 transfer beats reg write", d, 64'h7777_8888_9999_AAAA);

        report;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report;
    end

endmodule